// File: doc/BRIEF.md
# Transport-Stream Clock Recovery with PWM Steering

This block rebuilds the 27 MHz system time clock of a transport stream. It keeps a free-running time counter made of a 33-bit base and a 9-bit extension that counts 0 to 299. When a reference-carrying packet arrives, the surrounding logic pulses an arrival input and presents the received program clock reference (PCR). On that pulse the block latches the counter and the reference into internal registers and forms the signed tick difference, counter minus reference. In hardware mode the difference is clamped to the range of an 8-bit duty word, centred at mid-scale, and drives a PWM output with a 256-cycle period. That output feeds an external low-pass filter and voltage-controlled crystal oscillator, which close the loop toward a zero difference.

A range limit keeps implausible references out of the loop. A discontinuity flag that comes with the arrival marks a reference that must not steer the loop. In software mode the PWM stays frozen and the CPU runs the loop itself. It copies the latched values, or the live counter, into readable snapshot registers with transfer commands. It uses a sticky arrival flag to detect a reference that arrived during its read sequence, and then it repeats the read.

Top module: `pcr_clk_recover`

## Requirements
- R1: The time counter steps its extension from 0 to 299 on every clock. After 299 the extension returns to 0 and the base increments. Two live captures taken N clocks apart therefore differ by exactly N ticks, where ticks = base*300 + extension.
- R2: On an arrival pulse, the counter value at that edge and the input reference are latched. The transfer command at address 2 copies them into snapshots: bit 0 copies the latched counter and bit 1 copies the latched reference. Each snapshot reads as two words. The high word holds base bit 32 in bit 0 and the extension in bits 9:1. The low word holds base bits 31:0. The counter snapshot sits at addresses 3 (high) and 4 (low), and the reference snapshot at addresses 5 (high) and 6 (low).
- R3: In hardware mode an accepted arrival sets duty = clamp(difference, -128, 127) + 128. The PWM output is high for exactly duty cycles out of every 256.
- R4: After reset, all readable registers are 0, the interrupt is low and the duty is 128.
- R5: With the limit enable (control bit 1) set, an arrival whose |difference| is greater than the range field (control bits 31:16) leaves the duty unchanged. A value equal to the range is applied.
- R6: With software mode (control bit 0) set, arrivals leave the duty unchanged.
- R7: An arrival with the discontinuity input high leaves the duty unchanged, but it still latches its values.
- R8: With the interrupt enable (control bit 2) set, each arrival raises the interrupt output for exactly the one cycle after the arrival edge. With the enable clear, the output stays low.
- R9: Each arrival sets the arrival flag (address 1, bit 0). Writing 0 to that bit clears it, and writing 1 leaves it unchanged.
- R10: Snapshot registers change only on a transfer command. An arrival during a read sequence leaves them intact and sets the arrival flag, which tells the reader to retry.
- R11: Transfer bit 2 copies the live counter into the counter snapshot and overrides bit 0 when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 27 MHz tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pcr_arrive_i | input | 1 | One-cycle pulse when a reference packet arrives |
| pcr_disc_i | input | 1 | Reference breaks continuity; qualified by the arrival pulse |
| pcr_base_i | input | 33 | Received reference base |
| pcr_ext_i | input | 9 | Received reference extension (0 to 299) |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Arrival interrupt pulse |
| pwm_o | output | 1 | PWM steering output |

## Verification
The hardest case to reach from the ports is an exact, chosen difference at the moment of arrival. The counter runs freely and cannot be loaded. The bench therefore first takes a live capture and derives the fixed offset between its own cycle count and the counter. From then on it predicts the counter value at any arrival edge, and it builds each reference so that the difference lands on a clamp or range boundary, for example 127 against 128 or a range of 40 against 41. The retry case needs an arrival injected between a transfer command and the snapshot reads, which the bench places with directed timing.

// File: rtl/pcr_rec_pkg.sv
package pcr_rec_pkg;
  localparam int BASE_W  = 33;
  localparam int EXT_W   = 9;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int HI_BASE = BASE_W - DATA_W;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [EXT_W-1:0]  ext;
  } clk_ref_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_XFER   = 3'd2,
    A_STC_HI = 3'd3,
    A_STC_LO = 3'd4,
    A_PCR_HI = 3'd5,
    A_PCR_LO = 3'd6
  } reg_addr_e;

  localparam int C_SW  = 0;
  localparam int C_LIM = 1;
  localparam int C_IE  = 2;
  localparam int C_RNG = 16;

  localparam int X_STC  = 0;
  localparam int X_PCR  = 1;
  localparam int X_LIVE = 2;

  function automatic logic [DATA_W-1:0] hi_word(input clk_ref_t r);
    return DATA_W'({r.ext, r.base[BASE_W-1:DATA_W]});
  endfunction

  function automatic logic [DATA_W-1:0] lo_word(input clk_ref_t r);
    return r.base[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/pcr_stc_counter.sv
module pcr_stc_counter
  import pcr_rec_pkg::*;
#(
  parameter int EXT_MOD = 300
) (
  input  logic     clk,
  input  logic     rst,
  output clk_ref_t stc_o
);
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_MOD - 1);

  clk_ref_t stc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stc_q <= '0;
    end else if (stc_q.ext == EXT_LAST) begin
      stc_q.ext  <= '0;
      stc_q.base <= stc_q.base + BASE_W'(1);
    end else begin
      stc_q.ext <= stc_q.ext + EXT_W'(1);
    end
  end

  assign stc_o = stc_q;

  p_ext_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (stc_q.ext == EXT_LAST) |=>
      (stc_q.ext == '0) && (stc_q.base == $past(stc_q.base) + BASE_W'(1)));

  p_ext_step_r1: assert property (@(posedge clk) disable iff (rst)
    (stc_q.ext != EXT_LAST) |=>
      (stc_q.ext == $past(stc_q.ext) + EXT_W'(1)) && $stable(stc_q.base));
endmodule

// File: rtl/pcr_cmp_ctl.sv
module pcr_cmp_ctl
  import pcr_rec_pkg::*;
#(
  parameter int EXT_MOD = 300,
  parameter int DUTY_W  = 8,
  parameter int RANGE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arrive_i,
  input  logic               disc_i,
  input  clk_ref_t           stc_live_i,
  input  clk_ref_t           pcr_in_i,
  input  logic               sw_mode_i,
  input  logic               lim_en_i,
  input  logic [RANGE_W-1:0] range_i,
  output clk_ref_t           stc_lat_o,
  output clk_ref_t           pcr_lat_o,
  output logic [DUTY_W-1:0]  duty_o
);
  localparam int DW   = BASE_W + EXT_W + 2;
  localparam int HALF = 2 ** (DUTY_W - 1);
  localparam logic signed [DW-1:0] POS_LIM = DW'(HALF - 1);
  localparam logic signed [DW-1:0] NEG_LIM = -DW'(HALF);
  localparam logic signed [DW-1:0] MOD_S   = DW'(EXT_MOD);

  clk_ref_t stc_lat_q, pcr_lat_q;
  logic upd_q;
  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stc_lat_q <= '0;
      pcr_lat_q <= '0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= arrive_i && !disc_i;
      if (arrive_i) begin
        stc_lat_q <= stc_live_i;
        pcr_lat_q <= pcr_in_i;
      end
    end
  end

  logic signed [DW-1:0] d_base, d_ext, diff, mag;
  logic [DUTY_W-1:0] sat_duty;
  logic out_of_range;

  always_comb begin
    d_base = signed'(DW'(stc_lat_q.base)) - signed'(DW'(pcr_lat_q.base));
    d_ext  = signed'(DW'(stc_lat_q.ext))  - signed'(DW'(pcr_lat_q.ext));
    diff   = d_base * MOD_S + d_ext;
    mag    = (diff < 0) ? -diff : diff;
    out_of_range = mag > signed'(DW'(range_i));
    if (diff > POS_LIM)      sat_duty = {DUTY_W{1'b1}};
    else if (diff < NEG_LIM) sat_duty = '0;
    else                     sat_duty = DUTY_W'(diff + DW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= DUTY_W'(HALF);
    end else if (upd_q && !sw_mode_i && !(lim_en_i && out_of_range)) begin
      duty_q <= sat_duty;
    end
  end

  assign stc_lat_o = stc_lat_q;
  assign pcr_lat_o = pcr_lat_q;
  assign duty_o    = duty_q;

  p_lim_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_q && lim_en_i && (mag > signed'(DW'(range_i)))) |=> $stable(duty_q));

  p_sw_hold_r6: assert property (@(posedge clk) disable iff (rst)
    sw_mode_i |=> $stable(duty_q));

  p_disc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (arrive_i && disc_i) |=> ##1 $stable(duty_q));

  p_latch_r2: assert property (@(posedge clk) disable iff (rst)
    arrive_i |=> (pcr_lat_q == $past(pcr_in_i)) && (stc_lat_q == $past(stc_live_i)));
endmodule

// File: rtl/pcr_pwm_gen.sv
module pcr_pwm_gen #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int HALF = 2 ** (DUTY_W - 1);

  logic [DUTY_W-1:0] cnt_q, duty_act_q;
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      duty_act_q <= DUTY_W'(HALF);
      pwm_q      <= 1'b0;
    end else begin
      cnt_q <= cnt_q + DUTY_W'(1);
      pwm_q <= cnt_q < duty_act_q;
      if (cnt_q == {DUTY_W{1'b1}}) duty_act_q <= duty_i;
    end
  end

  assign pwm_o = pwm_q;

  p_duty_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != {DUTY_W{1'b1}}) |=> $stable(duty_act_q));
endmodule

// File: rtl/pcr_cpu_regs.sv
module pcr_cpu_regs
  import pcr_rec_pkg::*;
#(
  parameter int RANGE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arrive_i,
  input  clk_ref_t           stc_live_i,
  input  clk_ref_t           stc_lat_i,
  input  clk_ref_t           pcr_lat_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               sw_mode_o,
  output logic               lim_en_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               irq_o
);
  logic sw_q, lim_q, ie_q, flag_q, irq_q;
  logic [RANGE_W-1:0] rng_q;
  clk_ref_t stc_snap_q, pcr_snap_q;
  logic [DATA_W-1:0] rdata_q;

  wire unused_wbits = ^{wdata_i[C_RNG-1:C_IE+1]};

  wire wr_ctrl = wr_i && (addr_i == A_CTRL);
  wire wr_stat = wr_i && (addr_i == A_STAT);
  wire wr_xfer = wr_i && (addr_i == A_XFER);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q  <= 1'b0;
      lim_q <= 1'b0;
      ie_q  <= 1'b0;
      rng_q <= '0;
    end else if (wr_ctrl) begin
      sw_q  <= wdata_i[C_SW];
      lim_q <= wdata_i[C_LIM];
      ie_q  <= wdata_i[C_IE];
      rng_q <= wdata_i[C_RNG +: RANGE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= arrive_i && ie_q;
      if (arrive_i)                  flag_q <= 1'b1;
      else if (wr_stat && !wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stc_snap_q <= '0;
      pcr_snap_q <= '0;
    end else if (wr_xfer) begin
      if (wdata_i[X_LIVE])     stc_snap_q <= stc_live_i;
      else if (wdata_i[X_STC]) stc_snap_q <= stc_lat_i;
      if (wdata_i[X_PCR])      pcr_snap_q <= pcr_lat_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (addr_i)
        A_CTRL:   rdata_q <= DATA_W'({rng_q, {(C_RNG-C_IE-1){1'b0}}, ie_q, lim_q, sw_q});
        A_STAT:   rdata_q <= DATA_W'(flag_q);
        A_STC_HI: rdata_q <= hi_word(stc_snap_q);
        A_STC_LO: rdata_q <= lo_word(stc_snap_q);
        A_PCR_HI: rdata_q <= hi_word(pcr_snap_q);
        A_PCR_LO: rdata_q <= lo_word(pcr_snap_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o   = rdata_q;
  assign sw_mode_o = sw_q;
  assign lim_en_o  = lim_q;
  assign range_o   = rng_q;
  assign irq_o     = irq_q;

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (arrive_i && ie_q) |=> irq_o);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    arrive_i |=> flag_q);

  p_snap_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_xfer |=> $stable(stc_snap_q) && $stable(pcr_snap_q));
endmodule

// File: rtl/pcr_clk_recover.sv
module pcr_clk_recover
  import pcr_rec_pkg::*;
#(
  parameter int EXT_MOD = 300,
  parameter int DUTY_W  = 8,
  parameter int RANGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pcr_arrive_i,
  input  logic              pcr_disc_i,
  input  logic [32:0]       pcr_base_i,
  input  logic [8:0]        pcr_ext_i,
  input  logic [2:0]        bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              pwm_o
);
  clk_ref_t stc_live, stc_lat, pcr_lat, pcr_in;
  logic sw_mode, lim_en;
  logic [RANGE_W-1:0] range_w;
  logic [DUTY_W-1:0] duty;

  assign pcr_in.base = pcr_base_i;
  assign pcr_in.ext  = pcr_ext_i;

  pcr_stc_counter #(.EXT_MOD(EXT_MOD)) u_stc (
    .clk(clk), .rst(rst), .stc_o(stc_live)
  );

  pcr_cmp_ctl #(.EXT_MOD(EXT_MOD), .DUTY_W(DUTY_W), .RANGE_W(RANGE_W)) u_cmp (
    .clk(clk), .rst(rst),
    .arrive_i(pcr_arrive_i), .disc_i(pcr_disc_i),
    .stc_live_i(stc_live), .pcr_in_i(pcr_in),
    .sw_mode_i(sw_mode), .lim_en_i(lim_en), .range_i(range_w),
    .stc_lat_o(stc_lat), .pcr_lat_o(pcr_lat), .duty_o(duty)
  );

  pcr_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
    .clk(clk), .rst(rst), .duty_i(duty), .pwm_o(pwm_o)
  );

  pcr_cpu_regs #(.RANGE_W(RANGE_W)) u_regs (
    .clk(clk), .rst(rst),
    .arrive_i(pcr_arrive_i),
    .stc_live_i(stc_live), .stc_lat_i(stc_lat), .pcr_lat_i(pcr_lat),
    .addr_i(bus_addr_i), .wr_i(bus_wr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .sw_mode_o(sw_mode), .lim_en_o(lim_en), .range_o(range_w),
    .irq_o(irq_o)
  );
endmodule

// File: tb/pcr_clk_recover_test.sv
module pcr_clk_recover_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arrive = 1'b0, disc = 1'b0;
  logic [32:0] pbase = '0;
  logic [8:0]  pext = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, pwm;

  always #10 clk = ~clk;

  pcr_clk_recover uut (
    .clk(clk), .rst(rst), .pcr_arrive_i(arrive), .pcr_disc_i(disc),
    .pcr_base_i(pbase), .pcr_ext_i(pext), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .pwm_o(pwm)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  longint k_off, last_cyc, pcr_lin, stc_pred;

  typedef struct packed {
    int          off;
    logic        sw;
    logic        lim;
    logic        dsc;
    logic [15:0] rng;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{0,    1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{100,  1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{-60,  1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{127,  1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{-128, 1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{128,  1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{-129, 1'b0, 1'b0, 1'b0, 16'd0,  4'd3},
    '{40,   1'b0, 1'b1, 1'b0, 16'd40, 4'd5},
    '{41,   1'b0, 1'b1, 1'b0, 16'd40, 4'd5},
    '{-41,  1'b0, 1'b1, 1'b0, 16'd40, 4'd5},
    '{-40,  1'b0, 1'b1, 1'b0, 16'd40, 4'd5},
    '{10,   1'b1, 1'b0, 1'b0, 16'd0,  4'd6},
    '{10,   1'b0, 1'b0, 1'b1, 16'd0,  4'd7},
    '{10,   1'b0, 1'b0, 1'b0, 16'd0,  4'd3}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; last_cyc = cyc;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic rd_snap(input logic [2:0] hi_a, output longint lin, output int ext);
    logic [31:0] h, l;
    rd_reg(hi_a, h);
    rd_reg(hi_a + 3'd1, l);
    ext = int'(h[9:1]);
    lin = longint'({h[0], l}) * 300 + longint'(h[9:1]);
  endtask

  task automatic do_arrive(input int off, input logic d, input logic exp_irq, input string tag);
    @(negedge clk);
    stc_pred = cyc + 1 + k_off;
    pcr_lin  = stc_pred - longint'(off);
    pbase = 33'(pcr_lin / 300);
    pext  = 9'(pcr_lin % 300);
    disc = d; arrive = 1'b1;
    @(negedge clk); arrive = 1'b0; disc = 1'b0;
    check(tag, longint'(irq), longint'(exp_irq));
    @(negedge clk);
    check(tag, longint'(irq), 0);
  endtask

  task automatic measure_pwm(output int hi_cnt);
    hi_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pwm) hi_cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint lin, lin2, p_first;
    int ext, hc, exp_duty, diff;
    bit upd;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R4: reset state
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), d);
      check("R4", longint'(d), 0);
    end
    check("R4", longint'(irq), 0);
    repeat (300) @(negedge clk);
    measure_pwm(hc);
    check("R4", hc, 128);

    // R1/R11: calibrate against a live capture, then predict one later
    wr_reg(3'd2, 32'h4);
    rd_snap(3'd3, lin, ext);
    k_off = lin - last_cyc;
    check("R1", longint'(ext < 300), 1);
    repeat (6000) @(negedge clk);
    wr_reg(3'd2, 32'h4);
    rd_snap(3'd3, lin, ext);
    check("R1", lin, last_cyc + k_off);
    check("R1", longint'(ext < 300), 1);

    // Table of difference / mode vectors
    exp_duty = 128;
    for (int i = 0; i < NV; i++) begin
      wr_reg(3'd0, {VEC[i].rng, 13'd0, 1'b1, VEC[i].lim, VEC[i].sw});
      do_arrive(VEC[i].off, VEC[i].dsc, 1'b1, "R8");
      wr_reg(3'd2, 32'h3);
      rd_snap(3'd3, lin, ext);
      check("R2", lin, stc_pred);
      rd_snap(3'd5, lin, ext);
      check("R2", lin, pcr_lin);
      diff = VEC[i].off;
      upd = !VEC[i].sw && !VEC[i].dsc &&
            !(VEC[i].lim && ((diff < 0 ? -diff : diff) > int'(VEC[i].rng)));
      if (upd) exp_duty = (diff > 127) ? 255 : (diff < -128) ? 0 : diff + 128;
      repeat (600) @(negedge clk);
      measure_pwm(hc);
      check(tag_name(VEC[i].tag), hc, exp_duty);
    end

    // R9: arrival flag set / write-1 ignored / write-0 clears
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd1, d);
    check("R9", longint'(d[0]), 1);
    wr_reg(3'd1, 32'h1);
    rd_reg(3'd1, d);
    check("R9", longint'(d[0]), 1);
    wr_reg(3'd1, 32'h0);
    rd_reg(3'd1, d);
    check("R9", longint'(d[0]), 0);

    // R8: no pulse with enable clear; R10: snapshot held across mid-read arrival
    do_arrive(5, 1'b0, 1'b0, "R8");
    p_first = pcr_lin;
    wr_reg(3'd1, 32'h0);
    wr_reg(3'd2, 32'h3);
    rd_snap(3'd5, lin, ext);
    check("R10", lin, p_first);
    do_arrive(-7, 1'b0, 1'b0, "R10");
    rd_snap(3'd5, lin2, ext);
    check("R10", lin2, p_first);
    rd_reg(3'd1, d);
    check("R10", longint'(d[0]), 1);

    // R11: live copy overrides latched copy when both bits set
    repeat (50) @(negedge clk);
    wr_reg(3'd2, 32'h5);
    rd_snap(3'd3, lin, ext);
    check("R11", lin, last_cyc + k_off);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule